// File: doc/BRIEF.md
# Fixed-Length Parallel Packet Receiver

This block sits at the receiving end of an 8-bit, single-data-rate parallel streaming link driven by a processor. The sender provides a clock, an active-high enable strobe, a start strobe and a byte bus. The receiver takes one byte on each rising clock edge where enable is high. Each run of enable-high cycles is one burst, and every packet has a fixed length of `PKT_LEN` bytes.

Some senders hold enable high well past the last real byte and put filler on the bus during the extra cycles. For example, a 22-byte packet can come with a 38-cycle strobe. The receiver therefore keeps the first `PKT_LEN` bytes of each burst and silently drops the rest. It rejects a burst only when it is too short.

Accepted bytes are forwarded as they arrive on a byte/valid interface, and the final byte is marked. When the burst closes, a one-cycle verdict pulse reports whether the packet was good or short. Two saturating counters record short packets and over-long bursts for diagnostics. The wait line back to the sender is tied inactive, so the sender never stalls.

Top module: `fixlen_pkt_rx`

## Requirements
- R1: `wait_o` is 0 in every cycle, including during reset.
- R2: A byte on `data_i` is taken at a rising `clk` edge where `en_i` is 1. It appears on `out_data_o` with `out_valid_o` = 1 in the cycle that follows that edge. No byte is taken where `en_i` is 0.
- R3: Within one burst, only byte indices 0 to `PKT_LEN-1` (counted from 0 at the start of the burst) produce `out_valid_o`. `out_last_o` is 1 together with index `PKT_LEN-1` and never without `out_valid_o`. Bytes with index `PKT_LEN` or higher are dropped.
- R4: A burst closes at the first edge that samples `en_i` = 0 after an edge that sampled it as 1. When a burst that held at least `PKT_LEN` bytes closes, `good_o` is 1 for exactly the cycle after that edge. `good_o` and `err_o` are never both 1.
- R5: When a burst with fewer than `PKT_LEN` bytes closes, `err_o` is 1 for exactly the cycle after the closing edge, and `good_o` stays 0.
- R6: A new burst opens at an edge where `en_i` is 1 after a 0. An edge that samples both `start_i` = 1 and `en_i` = 1 while a burst is open closes that burst (its verdict follows as in R4 and R5) and opens a new one in which the byte at that edge has index 0.
- R7: `start_i` = 1 at an edge where `en_i` = 0 has no effect on any output.
- R8: `short_cnt_o` rises by one on each `err_o` verdict. `long_cnt_o` rises by one on each `good_o` verdict whose burst held more than `PKT_LEN` bytes. Both counters change in the same cycle as the verdict and stop at 2^`CNT_W`-1.
- R9: While `rst_n` is 0, `out_valid_o`, `out_last_o`, `good_o`, `err_o`, `out_data_o` and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable strobe, active high; marks byte cycles |
| start_i | input | 1 | Start strobe; restarts framing while enable is high |
| data_i | input | 8 | Byte bus from the sender |
| wait_o | output | 1 | Wait toward the sender, held at 0 |
| out_valid_o | output | 1 | Accepted byte present on `out_data_o` |
| out_data_o | output | 8 | Accepted byte |
| out_last_o | output | 1 | Marks the byte with index `PKT_LEN-1` |
| good_o | output | 1 | One-cycle pulse: closed burst had at least `PKT_LEN` bytes |
| err_o | output | 1 | One-cycle pulse: closed burst was short |
| short_cnt_o | output | CNT_W | Saturating count of short bursts |
| long_cnt_o | output | CNT_W | Saturating count of over-long accepted bursts |

## Verification
The bench sweeps every burst length from 1 to 40 through two copies of the block, one with a 22-byte packet and one with a 24-byte packet. Lengths one below, equal to and one above each packet length are therefore all covered. A design that let the index wrap or failed to saturate it would forward filler bytes or a second `out_last_o` in long bursts. A design with an off-by-one compare would reject exact-length packets, or accept packets one byte short. Restarts are driven mid-burst, at exactly `PKT_LEN` and on every cycle of a burst. A design that ignored `start_i` would merge two packets into one verdict. Stray start pulses with enable low, together with a counter narrow enough to saturate, catch a design that reacts to an idle start or lets a counter wrap back to zero.

// File: rtl/fixlen_pkt_rx_pkg.sv
package fixlen_pkt_rx_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Outcome of a burst that has just closed
    typedef enum logic [1:0] {
        VERDICT_NONE  = 2'd0,
        VERDICT_GOOD  = 2'd1,
        VERDICT_SHORT = 2'd2
    } verdict_e;

    // One beat toward the consumer
    typedef struct packed {
        logic  valid;
        byte_t data;
        logic  last;
    } beat_t;

endpackage

// File: rtl/fixlen_pkt_rx_framer.sv
module fixlen_pkt_rx_framer #(
    parameter int PKT_LEN = 22,
    parameter int IDX_W   = $clog2(PKT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    output logic             take_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             close_o,
    output logic             close_full_o,
    output logic             close_extra_o
);
    localparam logic [IDX_W-1:0] LEN_C = IDX_W'(PKT_LEN);

    typedef struct packed {
        logic             en_q;
        logic [IDX_W-1:0] cnt;
        logic             extra;
    } frame_t;

    frame_t st_q, st_d;
    logic             open_w;
    logic [IDX_W-1:0] base_w;

    always_comb begin
        st_d    = st_q;
        open_w  = en_i && (!st_q.en_q || start_i);
        close_o = st_q.en_q && (!en_i || start_i);
        base_w  = open_w ? '0 : st_q.cnt;
        take_o  = en_i && (base_w < LEN_C);
        idx_o   = base_w;

        close_full_o  = close_o && (st_q.cnt == LEN_C);
        close_extra_o = close_full_o && st_q.extra;

        st_d.en_q  = en_i;
        st_d.cnt   = base_w;
        st_d.extra = open_w ? 1'b0 : st_q.extra;
        if (en_i) begin
            if (take_o) begin
                st_d.cnt = base_w + IDX_W'(1);
            end else begin
                // index pinned at PKT_LEN: byte is filler
                st_d.extra = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fixlen_pkt_rx_outreg.sv
module fixlen_pkt_rx_outreg
    import fixlen_pkt_rx_pkg::*;
#(
    parameter int PKT_LEN = 22,
    parameter int IDX_W   = $clog2(PKT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  byte_t            data_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             close_i,
    input  logic             close_full_i,
    output beat_t            beat_o,
    output verdict_e         verdict_o
);
    localparam logic [IDX_W-1:0] LAST_C = IDX_W'(PKT_LEN - 1);

    typedef struct packed {
        beat_t    beat;
        verdict_e verdict;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d.beat.valid = take_i;
        o_d.beat.data  = take_i ? data_i : '0;
        o_d.beat.last  = take_i && (idx_i == LAST_C);
        if (!close_i) begin
            o_d.verdict = VERDICT_NONE;
        end else if (close_full_i) begin
            o_d.verdict = VERDICT_GOOD;
        end else begin
            o_d.verdict = VERDICT_SHORT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{beat: '0, verdict: VERDICT_NONE};
        end else begin
            o_q <= o_d;
        end
    end

    assign beat_o    = o_q.beat;
    assign verdict_o = o_q.verdict;

endmodule

// File: rtl/fixlen_pkt_rx_stats.sv
module fixlen_pkt_rx_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_short_i,
    input  logic             inc_long_i,
    output logic [CNT_W-1:0] short_cnt_o,
    output logic [CNT_W-1:0] long_cnt_o
);
    localparam int                NUM_CTR = 2;
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;

    logic [NUM_CTR-1:0]   bump_w;
    logic [CNT_W-1:0]     val_w [NUM_CTR];

    assign bump_w = {inc_long_i, inc_short_i};

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic [CNT_W-1:0] cnt_q, cnt_d;

        always_comb begin
            cnt_d = cnt_q;
            if (bump_w[g] && (cnt_q != CNT_MAX)) begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign val_w[g] = cnt_q;
    end

    assign short_cnt_o = val_w[0];
    assign long_cnt_o  = val_w[1];

endmodule

// File: rtl/fixlen_pkt_rx.sv
module fixlen_pkt_rx
    import fixlen_pkt_rx_pkg::*;
#(
    parameter int PKT_LEN = 22,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              wait_o,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_data_o,
    output logic              out_last_o,
    output logic              good_o,
    output logic              err_o,
    output logic [CNT_W-1:0]  short_cnt_o,
    output logic [CNT_W-1:0]  long_cnt_o
);
    localparam int IDX_W = $clog2(PKT_LEN + 1);

    logic             take_w;
    logic [IDX_W-1:0] idx_w;
    logic             close_w;
    logic             close_full_w;
    logic             close_extra_w;
    beat_t            beat_w;
    verdict_e         verdict_w;

    fixlen_pkt_rx_framer #(
        .PKT_LEN (PKT_LEN),
        .IDX_W   (IDX_W)
    ) u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en_i),
        .start_i       (start_i),
        .take_o        (take_w),
        .idx_o         (idx_w),
        .close_o       (close_w),
        .close_full_o  (close_full_w),
        .close_extra_o (close_extra_w)
    );

    fixlen_pkt_rx_outreg #(
        .PKT_LEN (PKT_LEN),
        .IDX_W   (IDX_W)
    ) u_outreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take_w),
        .data_i       (data_i),
        .idx_i        (idx_w),
        .close_i      (close_w),
        .close_full_i (close_full_w),
        .beat_o       (beat_w),
        .verdict_o    (verdict_w)
    );

    fixlen_pkt_rx_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_short_i (close_w && !close_full_w),
        .inc_long_i  (close_extra_w),
        .short_cnt_o (short_cnt_o),
        .long_cnt_o  (long_cnt_o)
    );

    // sender is never paused
    assign wait_o      = 1'b0;
    assign out_valid_o = beat_w.valid;
    assign out_data_o  = beat_w.data;
    assign out_last_o  = beat_w.last;
    assign good_o      = (verdict_w == VERDICT_GOOD);
    assign err_o       = (verdict_w == VERDICT_SHORT);

endmodule

// File: rtl/fixlen_pkt_rx_chk.sv
module fixlen_pkt_rx_chk #(
    parameter int PKT_LEN = 22,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             start_i,
    input logic             wait_o,
    input logic             out_valid_o,
    input logic             out_last_o,
    input logic             good_o,
    input logic             err_o,
    input logic [CNT_W-1:0] short_cnt_o
);
    localparam logic [15:0]      LEN16   = 16'(PKT_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // bytes forwarded since the last verdict
    logic [15:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (good_o || err_o) begin
            seen_q <= out_valid_o ? 16'd1 : 16'd0;
        end else if (out_valid_o && (seen_q != 16'hFFFF)) begin
            seen_q <= seen_q + 16'd1;
        end
    end

    p_wait_low_r1: assert property (@(posedge clk) wait_o == 1'b0);

    p_valid_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(en_i));

    p_last_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q <= LEN16);

    p_last_position_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last_o && !good_o && !err_o) |-> (seen_q == LEN16 - 16'd1));

    p_good_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        good_o |-> (seen_q == LEN16));

    p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({good_o, err_o}));

    p_err_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (seen_q < LEN16));

    p_verdict_at_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (good_o || err_o) |-> ($past(!en_i) || $past(start_i)));

    p_short_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ((short_cnt_o == $past(short_cnt_o) + CNT_W'(1)) ||
                   (short_cnt_o == CNT_MAX)));

    p_short_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> $stable(short_cnt_o));

endmodule

bind fixlen_pkt_rx fixlen_pkt_rx_chk #(
    .PKT_LEN (PKT_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .start_i     (start_i),
    .wait_o      (wait_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .good_o      (good_o),
    .err_o       (err_o),
    .short_cnt_o (short_cnt_o)
);

// File: tb/fixlen_pkt_rx_tb.sv
module fixlen_pkt_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_A = 22;
    localparam int LEN_B = 24;
    localparam int CW_A  = 8;
    localparam int CW_B  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] data_i = '0;

    logic            wait_a, val_a, last_a, good_a, err_a;
    logic [7:0]      dat_a;
    logic [CW_A-1:0] sh_a, lg_a;
    logic            wait_b, val_b, last_b, good_b, err_b;
    logic [7:0]      dat_b;
    logic [CW_B-1:0] sh_b, lg_b;

    int checks = 0;
    int fails  = 0;

    // bench-side burst tracking, per instance
    int  t_cnt[2]   = '{0, 0};
    bit  t_extra[2] = '{0, 0};
    bit  p_en       = 0;
    int  e_short[2] = '{0, 0};
    int  e_long[2]  = '{0, 0};
    int  lens[2]    = '{LEN_A, LEN_B};
    int  cmax[2]    = '{(1 << CW_A) - 1, (1 << CW_B) - 1};

    always #(CLK_PERIOD/2) clk = ~clk;

    fixlen_pkt_rx #(.PKT_LEN(LEN_A), .CNT_W(CW_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i), .data_i(data_i),
        .wait_o(wait_a), .out_valid_o(val_a), .out_data_o(dat_a), .out_last_o(last_a),
        .good_o(good_a), .err_o(err_a), .short_cnt_o(sh_a), .long_cnt_o(lg_a));

    fixlen_pkt_rx #(.PKT_LEN(LEN_B), .CNT_W(CW_B)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(start_i), .data_i(data_i),
        .wait_o(wait_b), .out_valid_o(val_b), .out_data_o(dat_b), .out_last_o(last_b),
        .good_o(good_b), .err_o(err_b), .short_cnt_o(sh_b), .long_cnt_o(lg_b));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_counts(input int k);
        int es = (e_short[k] > cmax[k]) ? cmax[k] : e_short[k];
        int el = (e_long[k]  > cmax[k]) ? cmax[k] : e_long[k];
        if (k == 0) begin
            chk("R8 short_cnt A", int'(sh_a), es);
            chk("R8 long_cnt A",  int'(lg_a), el);
        end else begin
            chk("R8 short_cnt B", int'(sh_b), es);
            chk("R8 long_cnt B",  int'(lg_b), el);
        end
    endtask

    // One link cycle: drive at negedge, check a quarter period after posedge
    task automatic step(input bit en, input bit st, input logic [7:0] d);
        bit ev[2], el[2], eg[2], ee[2];
        bit opn, cls;
        @(negedge clk);
        en_i = en; start_i = st; data_i = d;
        opn = en && (!p_en || st);
        cls = p_en && (!en || st);
        for (int k = 0; k < 2; k++) begin
            int base = opn ? 0 : t_cnt[k];
            ev[k] = en && (base < lens[k]);
            el[k] = ev[k] && (base == lens[k] - 1);
            eg[k] = cls && (t_cnt[k] == lens[k]);
            ee[k] = cls && (t_cnt[k] < lens[k]);
            if (ee[k]) e_short[k]++;
            if (eg[k] && t_extra[k]) e_long[k]++;
            if (opn) t_extra[k] = 0;
            if (en) begin
                if (ev[k]) t_cnt[k] = base + 1;
                else begin t_cnt[k] = base; t_extra[k] = 1; end
            end
        end
        p_en = en;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R1 wait low", int'(wait_a | wait_b), 0);
        chk("R2/R3 valid A", int'(val_a), int'(ev[0]));
        chk("R2/R3 valid B", int'(val_b), int'(ev[1]));
        if (ev[0]) chk("R2 data A", int'(dat_a), int'(d));
        if (ev[1]) chk("R2 data B", int'(dat_b), int'(d));
        chk("R3 last A", int'(last_a), int'(el[0]));
        chk("R3 last B", int'(last_b), int'(el[1]));
        chk("R4/R6 good A", int'(good_a), int'(eg[0]));
        chk("R4/R6 good B", int'(good_b), int'(eg[1]));
        chk("R5/R6 err A", int'(err_a), int'(ee[0]));
        chk("R5/R6 err B", int'(err_b), int'(ee[1]));
        chk_counts(0);
        chk_counts(1);
    endtask

    task automatic burst(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            step(1'b1, 1'b0, 8'(seed * 7 + i * 3 + 1));
        end
    endtask

    task automatic idle(input int n, input bit st);
        for (int i = 0; i < n; i++) step(1'b0, st, 8'hC3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state, with live stimulus on the link
        en_i = 1'b1; start_i = 1'b1; data_i = 8'h5A;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R9 reset valid",   int'(val_a | val_b), 0);
        chk("R9 reset data",    int'(dat_a | dat_b), 0);
        chk("R9 reset pulses",  int'(good_a | err_a | good_b | err_b | last_a | last_b), 0);
        chk("R9 reset counts",  int'(sh_a) + int'(lg_a) + int'(sh_b) + int'(lg_b), 0);
        chk("R1 wait in reset", int'(wait_a | wait_b), 0);
        @(negedge clk);
        en_i = 1'b0; start_i = 1'b0;
        rst_n = 1'b1;

        // R7: idle start pulses do nothing
        idle(2, 1'b0);
        idle(4, 1'b1);
        idle(1, 1'b0);

        // R2-R5, R8: every burst length 1..40, twice (saturates B counters)
        for (int pass = 0; pass < 2; pass++) begin
            for (int len = 1; len <= 40; len++) begin
                burst(len, len + pass);
                idle(2, 1'b0);
                idle(1, 1'b1);   // R7 between bursts
            end
        end

        // R6: restart mid-burst, exactly at the packet length, and past it
        burst(10, 1);
        step(1'b1, 1'b1, 8'h11);
        burst(LEN_A + 3, 2);
        idle(2, 1'b0);
        burst(LEN_A, 3);
        step(1'b1, 1'b1, 8'h22);
        burst(LEN_B - 1, 4);
        idle(2, 1'b0);
        burst(LEN_B + 5, 5);
        step(1'b1, 1'b1, 8'h33);
        burst(LEN_B + 1, 6);
        idle(2, 1'b0);
        // R6: start on every byte of a burst -> one-byte packets
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 8'(i + 40));
        idle(2, 1'b0);
        // R6: start coincident with the opening edge
        step(1'b1, 1'b1, 8'h44);
        burst(LEN_A - 1, 7);
        idle(3, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule